// File: doc/BRIEF.md
# Watchdog Register Front End with Magic-Value Unlock

This block sits between a simple synchronous register bus and a watchdog counting core. It decodes bus writes and reads in two address spaces. The memory window holds the two countdown preload values and the service register. The configuration space holds a 16-bit control register and an 8-bit lock register. The block drives the preload values, a one-cycle kick pulse, a one-cycle flag-clear pulse and the static configuration fields into the core. It returns read data one cycle after a read strobe.

Software cannot change the preloads or service the watchdog with a single stray store. Each protected write needs a fresh two-step handshake at the service offset: first the value 0x80, then 0x86. The next memory-window write of any other kind consumes the grant, whether or not that write changes anything. Protected writes made without the handshake are dropped without any error indication.

Access width is coded on `bus_size`: 0 is one byte, 1 is two bytes, 2 is four bytes, and 3 is not a legal access, so the block ignores it. Before any comparison, the write data is cut to the access width. The core owns the previous-reboot flag. This block only reports it on reads and requests its clearing.

Top module: `wdt_regif`

## Requirements
- R1: During and after reset, the unlock sequence is idle, both preloads are 0xFFFFF, reboot_en is 1, fast_clk, irq_type, free_run, wdt_en, wdt_lock, kick and flag_clr are all 0, and bus_rdata is 0.
- R2: A memory-window write of width-cut value 0x80 at offset 0x0C arms the sequence from any state. Width-cut value 0x86 at 0x0C while armed opens it. Byte, half and word accesses all count. While armed, other writes leave the sequence armed.
- R3: 0x86 written at 0x0C while not armed does not open the sequence, and a protected write after it is dropped.
- R4: While open, a 4-byte write at offset 0x00 loads preload1, and one at 0x04 loads preload2, each from bits [19:0] of the data. Without the open state, such writes leave both preloads unchanged.
- R5: While open, a 2-byte write at 0x0C with bit 8 set raises kick for exactly the one cycle after the write.
- R6: While open, a 2-byte write at 0x0C with bit 9 or bit 12 set raises flag_clr for exactly the one cycle after the write. Bit 8 and bit 9 together give both pulses.
- R7: Any memory-window write made while open, other than a 0x80 at 0x0C, returns the sequence to idle. This includes writes with no effect, byte writes and a repeated 0x86. A second protected write then needs a new handshake.
- R8: A 2-byte read at memory offset 0x0C returns 0x1200 (bits 9 and 12) when prev_reboot is 1 and 0 otherwise. Every other memory-window read returns 0. bus_rdata updates on the edge that samples bus_re and holds while bus_re is low.
- R9: A 2-byte write at config offset 0x0 sets reboot_en to the inverse of bit 5, fast_clk to bit 2 and irq_type to bits [1:0]. A 2-byte read there returns the same layout. Other widths at that offset neither write nor read it (a read returns 0).
- R10: A 1-byte write at config offset 0x4 sets free_run from bit 2, wdt_en from bit 1 and wdt_lock from bit 0. A 1-byte read there returns that layout. Other widths are ignored.
- R11: Once wdt_lock is 1, writes to the lock register have no effect until reset.
- R12: Config-space accesses never change the state of the unlock sequence, whether it is armed or open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cfg | input | 1 | 1 selects configuration space, 0 the memory window |
| bus_addr | input | ADDR_W | Byte offset in the selected space |
| bus_size | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 ignored |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| prev_reboot | input | 1 | Previous-reboot flag from the core |
| preload1 | output | PRE_W | First-stage countdown preload |
| preload2 | output | PRE_W | Second-stage countdown preload |
| kick | output | 1 | Keep-alive pulse |
| flag_clr | output | 1 | Request to clear the previous-reboot flag |
| reboot_en | output | 1 | Reboot on second-stage expiry |
| fast_clk | output | 1 | Selects the fast decrement scale |
| irq_type | output | 2 | First-stage interrupt type |
| free_run | output | 1 | Restart after second-stage expiry |
| wdt_en | output | 1 | Watchdog enable |
| wdt_lock | output | 1 | Sticky lock of the lock register |

## Verification
The properties assume that bus_we and bus_re are never high in the same cycle and that each strobe marks one access, with address, size and data stable around the sampling edge. The hold check on bus_rdata also assumes that reads happen only through bus_re. The stimulus drives every access at the falling edge for exactly one cycle, with the strobes mutually exclusive and only legal size codes. The sequences interleave config accesses, no-effect writes and repeated magic values with the handshake, so that the arming, opening and spending paths are all taken.

// File: rtl/wdt_regif_pkg.sv
package wdt_regif_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_ARMED = 2'd1,
    UL_OPEN  = 2'd2
  } unlock_e;

  typedef struct packed {
    logic       reboot_en;
    logic       fast_clk;
    logic [1:0] irq_type;
  } ctl_fields_t;

  typedef struct packed {
    logic free_run;
    logic enable;
    logic lock;
  } lock_fields_t;

  localparam logic [31:0] KEY_FIRST  = 32'h0000_0080;
  localparam logic [31:0] KEY_SECOND = 32'h0000_0086;

  localparam int CTL_NOREBOOT_BIT = 5;
  localparam int CTL_FAST_BIT     = 2;
  localparam int LCK_FREE_BIT     = 2;
  localparam int LCK_EN_BIT       = 1;
  localparam int LCK_LOCK_BIT     = 0;
  localparam int SVC_KICK_BIT     = 8;
  localparam int SVC_FLAG_BIT_A   = 9;
  localparam int SVC_FLAG_BIT_B   = 12;

  function automatic logic size_legal(input logic [1:0] sz);
    return sz != SZ_NONE;
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    logic [31:0] m;
    case (sz)
      SZ_BYTE: m = 32'h0000_00FF;
      SZ_HALF: m = 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

  function automatic logic [15:0] ctl_pack(input ctl_fields_t c);
    logic [15:0] w;
    w                   = '0;
    w[CTL_NOREBOOT_BIT] = ~c.reboot_en;
    w[CTL_FAST_BIT]     = c.fast_clk;
    w[1:0]              = c.irq_type;
    return w;
  endfunction

  function automatic ctl_fields_t ctl_unpack(input logic [15:0] w);
    ctl_fields_t c;
    c.reboot_en = ~w[CTL_NOREBOOT_BIT];
    c.fast_clk  = w[CTL_FAST_BIT];
    c.irq_type  = w[1:0];
    return c;
  endfunction

  function automatic logic [7:0] lock_pack(input lock_fields_t l);
    logic [7:0] w;
    w               = '0;
    w[LCK_FREE_BIT] = l.free_run;
    w[LCK_EN_BIT]   = l.enable;
    w[LCK_LOCK_BIT] = l.lock;
    return w;
  endfunction

  function automatic lock_fields_t lock_unpack(input logic [7:0] w);
    lock_fields_t l;
    l.free_run = w[LCK_FREE_BIT];
    l.enable   = w[LCK_EN_BIT];
    l.lock     = w[LCK_LOCK_BIT];
    return l;
  endfunction

  function automatic logic [15:0] flag_word(input logic f);
    logic [15:0] w;
    w                 = '0;
    w[SVC_FLAG_BIT_A] = f;
    w[SVC_FLAG_BIT_B] = f;
    return w;
  endfunction

  function automatic logic svc_kick(input logic [31:0] w);
    return w[SVC_KICK_BIT];
  endfunction

  function automatic logic svc_clear(input logic [31:0] w);
    return w[SVC_FLAG_BIT_A] | w[SVC_FLAG_BIT_B];
  endfunction

endpackage

// File: rtl/wdt_unlock_seq.sv
module wdt_unlock_seq
  import wdt_regif_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int KEY_OFS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mem,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wval,
  output logic              arm_hit,
  output logic              open_hit,
  output logic              grant,
  output unlock_e           state
);

  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFS);

  logic    at_key;
  unlock_e state_d;

  always_comb begin
    at_key   = (addr == KEY_A);
    arm_hit  = wr_mem && at_key && (wval == KEY_FIRST);
    open_hit = wr_mem && at_key && (wval == KEY_SECOND) && (state == UL_ARMED);
    grant    = wr_mem && (state == UL_OPEN) && !arm_hit;
  end

  always_comb begin
    state_d = state;
    if (arm_hit)       state_d = UL_ARMED;
    else if (open_hit) state_d = UL_OPEN;
    else if (grant)    state_d = UL_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= UL_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/wdt_prot_regs.sv
module wdt_prot_regs
  import wdt_regif_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PRE_W    = 20,
  parameter int PRE1_OFS = 0,
  parameter int PRE2_OFS = 4,
  parameter int KEY_OFS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wval,
  output logic [PRE_W-1:0]  preload1,
  output logic [PRE_W-1:0]  preload2,
  output logic              kick,
  output logic              flag_clr
);

  localparam int N_PRE = 2;
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFS);
  localparam logic [ADDR_W-1:0] PRE_A [N_PRE] = '{ADDR_W'(PRE1_OFS), ADDR_W'(PRE2_OFS)};

  logic [PRE_W-1:0] pre_q [N_PRE];
  logic             svc_wr;

  assign svc_wr = grant && (size == SZ_HALF) && (addr == KEY_A);

  for (genvar i = 0; i < N_PRE; i++) begin : g_pre
    logic ld;
    assign ld = grant && (size == SZ_WORD) && (addr == PRE_A[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pre_q[i] <= '1;
      else if (ld) pre_q[i] <= wval[PRE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick     <= 1'b0;
      flag_clr <= 1'b0;
    end else begin
      kick     <= svc_wr && svc_kick(wval);
      flag_clr <= svc_wr && svc_clear(wval);
    end
  end

  assign preload1 = pre_q[0];
  assign preload2 = pre_q[1];

endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_regif_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CTL_OFS = 0,
  parameter int LCK_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [15:0]       wval,
  output ctl_fields_t       ctl,
  output lock_fields_t      lck,
  output logic              ctl_wr,
  output logic              lck_wr
);

  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] LCK_A = ADDR_W'(LCK_OFS);
  localparam ctl_fields_t  CTL_RST = '{reboot_en: 1'b1, fast_clk: 1'b0, irq_type: 2'd0};
  localparam lock_fields_t LCK_RST = '{free_run: 1'b0, enable: 1'b0, lock: 1'b0};

  always_comb begin
    ctl_wr = wr_cfg && (addr == CTL_A) && (size == SZ_HALF);
    lck_wr = wr_cfg && (addr == LCK_A) && (size == SZ_BYTE) && !lck.lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= CTL_RST;
      lck <= LCK_RST;
    end else begin
      if (ctl_wr) ctl <= ctl_unpack(wval);
      if (lck_wr) lck <= lock_unpack(wval[7:0]);
    end
  end

endmodule

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_regif_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PRE_W    = 20,
  parameter int PRE1_OFS = 0,
  parameter int PRE2_OFS = 4,
  parameter int KEY_OFS  = 12,
  parameter int CTL_OFS  = 0,
  parameter int LCK_OFS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cfg,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              prev_reboot,
  output logic [PRE_W-1:0]  preload1,
  output logic [PRE_W-1:0]  preload2,
  output logic              kick,
  output logic              flag_clr,
  output logic              reboot_en,
  output logic              fast_clk,
  output logic [1:0]        irq_type,
  output logic              free_run,
  output logic              wdt_en,
  output logic              wdt_lock
);

  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFS);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] LCK_A = ADDR_W'(LCK_OFS);

  logic [31:0]  wval;
  logic         acc_ok;
  logic         wr_mem;
  logic         wr_cfg;
  logic         key_arm;
  logic         key_open;
  logic         prot_grant;
  unlock_e      ul_state;
  ctl_fields_t  ctl;
  lock_fields_t lck;
  logic         ctl_wr;
  logic         lck_wr;
  logic [31:0]  rd_val;

  always_comb begin
    acc_ok = size_legal(bus_size);
    wval   = bus_wdata & size_mask(bus_size);
    wr_mem = bus_we && acc_ok && !bus_cfg;
    wr_cfg = bus_we && acc_ok && bus_cfg;
  end

  wdt_unlock_seq #(
    .ADDR_W (ADDR_W),
    .KEY_OFS(KEY_OFS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mem  (wr_mem),
    .addr    (bus_addr),
    .wval    (wval),
    .arm_hit (key_arm),
    .open_hit(key_open),
    .grant   (prot_grant),
    .state   (ul_state)
  );

  wdt_prot_regs #(
    .ADDR_W  (ADDR_W),
    .PRE_W   (PRE_W),
    .PRE1_OFS(PRE1_OFS),
    .PRE2_OFS(PRE2_OFS),
    .KEY_OFS (KEY_OFS)
  ) u_prot (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant   (prot_grant),
    .addr    (bus_addr),
    .size    (bus_size),
    .wval    (wval),
    .preload1(preload1),
    .preload2(preload2),
    .kick    (kick),
    .flag_clr(flag_clr)
  );

  wdt_cfg_regs #(
    .ADDR_W (ADDR_W),
    .CTL_OFS(CTL_OFS),
    .LCK_OFS(LCK_OFS)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_cfg(wr_cfg),
    .addr  (bus_addr),
    .size  (bus_size),
    .wval  (wval[15:0]),
    .ctl   (ctl),
    .lck   (lck),
    .ctl_wr(ctl_wr),
    .lck_wr(lck_wr)
  );

  always_comb begin
    rd_val = '0;
    if (bus_cfg) begin
      if (bus_addr == CTL_A && bus_size == SZ_HALF)      rd_val = {16'h0, ctl_pack(ctl)};
      else if (bus_addr == LCK_A && bus_size == SZ_BYTE) rd_val = {24'h0, lock_pack(lck)};
    end else begin
      if (bus_addr == KEY_A && bus_size == SZ_HALF)      rd_val = {16'h0, flag_word(prev_reboot)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_rdata <= '0;
    else if (bus_re && acc_ok)   bus_rdata <= rd_val;
  end

  assign reboot_en = ctl.reboot_en;
  assign fast_clk  = ctl.fast_clk;
  assign irq_type  = ctl.irq_type;
  assign free_run  = lck.free_run;
  assign wdt_en    = lck.enable;
  assign wdt_lock  = lck.lock;

endmodule

// File: rtl/wdt_regif_chk.sv
module wdt_regif_chk #(
  parameter int PRE_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             bus_re,
  input logic             bus_cfg,
  input logic [31:0]      bus_rdata,
  input logic [PRE_W-1:0] preload1,
  input logic [PRE_W-1:0] preload2,
  input logic             kick,
  input logic             flag_clr,
  input logic             free_run,
  input logic             wdt_en,
  input logic             wdt_lock,
  input logic [1:0]       ul_state,
  input logic             prot_grant
);

  a_r2_open_after_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (ul_state == 2'd2 && $past(ul_state) != 2'd2) |-> $past(ul_state) == 2'd1);

  a_r4_preload_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_grant |=> ($stable(preload1) && $stable(preload2)));

  a_r5_pulse_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_grant |=> (!kick && !flag_clr));

  a_r5_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);

  a_r6_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag_clr);

  a_r7_grant_spent: assert property (@(posedge clk) disable iff (!rst_n)
    prot_grant |=> ul_state == 2'd0);

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_lock |=> (wdt_lock && $stable(wdt_en) && $stable(free_run)));

  a_r12_cfg_keeps_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_cfg) |=> $stable(ul_state));

endmodule

bind wdt_regif wdt_regif_chk #(.PRE_W(PRE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_cfg   (bus_cfg),
  .bus_rdata (bus_rdata),
  .preload1  (preload1),
  .preload2  (preload2),
  .kick      (kick),
  .flag_clr  (flag_clr),
  .free_run  (free_run),
  .wdt_en    (wdt_en),
  .wdt_lock  (wdt_lock),
  .ul_state  (ul_state),
  .prot_grant(prot_grant)
);

// File: tb/sim_wdt_regif.sv
`timescale 1ns/100ps
module sim_wdt_regif;

  localparam int AW = 8;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_cfg = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_size = 2'd0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [31:0]   bus_rdata;
  logic          prev_reboot = 1'b0;
  logic [PW-1:0] preload1, preload2;
  logic          kick, flag_clr, reboot_en, fast_clk, free_run, wdt_en, wdt_lock;
  logic [1:0]    irq_type;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdt_regif #(.ADDR_W(AW), .PRE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cfg(bus_cfg), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .prev_reboot(prev_reboot), .preload1(preload1),
    .preload2(preload2), .kick(kick), .flag_clr(flag_clr), .reboot_en(reboot_en),
    .fast_clk(fast_clk), .irq_type(irq_type), .free_run(free_run), .wdt_en(wdt_en),
    .wdt_lock(wdt_lock)
  );

  // behavioural reference
  int          m_seq;
  int          m_p1, m_p2;
  bit          m_kick, m_clr, m_reb, m_fast, m_fr, m_en, m_lk;
  int          m_it;
  int unsigned m_rd;

  always @(posedge clk) begin
    int unsigned v;
    if (!rst_n) begin
      m_seq = 0; m_p1 = 'hFFFFF; m_p2 = 'hFFFFF; m_kick = 0; m_clr = 0;
      m_reb = 1; m_fast = 0; m_it = 0; m_fr = 0; m_en = 0; m_lk = 0; m_rd = 0;
    end else begin
      m_kick = 0; m_clr = 0;
      v = bus_wdata;
      if (bus_size == 0) v = v % 256;
      if (bus_size == 1) v = v % 65536;
      if (bus_we && bus_size != 3) begin
        if (!bus_cfg) begin
          if (bus_addr == 12 && v == 'h80) m_seq = 1;
          else if (bus_addr == 12 && v == 'h86 && m_seq == 1) m_seq = 2;
          else if (m_seq == 2) begin
            if (bus_size == 2 && bus_addr == 0) m_p1 = v % (1 << 20);
            if (bus_size == 2 && bus_addr == 4) m_p2 = v % (1 << 20);
            if (bus_size == 1 && bus_addr == 12) begin
              m_kick = ((v >> 8) & 1) != 0;
              m_clr  = ((v >> 9) & 1) != 0 || ((v >> 12) & 1) != 0;
            end
            m_seq = 0;
          end
        end else begin
          if (bus_addr == 0 && bus_size == 1) begin
            m_reb = ((v >> 5) & 1) == 0; m_fast = ((v >> 2) & 1) != 0; m_it = v % 4;
          end
          if (bus_addr == 4 && bus_size == 0 && !m_lk) begin
            m_fr = ((v >> 2) & 1) != 0; m_en = ((v >> 1) & 1) != 0; m_lk = (v & 1) != 0;
          end
        end
      end
      if (bus_re && bus_size != 3) begin
        m_rd = 0;
        if (bus_cfg && bus_addr == 0 && bus_size == 1)
          m_rd = (m_reb ? 0 : 32) + (m_fast ? 4 : 0) + m_it;
        else if (bus_cfg && bus_addr == 4 && bus_size == 0)
          m_rd = (m_fr ? 4 : 0) + (m_en ? 2 : 0) + (m_lk ? 1 : 0);
        else if (!bus_cfg && bus_addr == 12 && bus_size == 1)
          m_rd = prev_reboot ? 'h1200 : 0;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  bit armed_cmp = 0;
  always @(negedge clk) begin
    if (rst_n && armed_cmp && !done) begin
      chk("R4 preload1", preload1, m_p1);
      chk("R4 preload2", preload2, m_p2);
      chk("R5 kick", kick, m_kick);
      chk("R6 flag_clr", flag_clr, m_clr);
      chk("R9 reboot_en", reboot_en, m_reb);
      chk("R9 fast_clk", fast_clk, m_fast);
      chk("R9 irq_type", irq_type, m_it);
      chk("R10 free_run", free_run, m_fr);
      chk("R10 wdt_en", wdt_en, m_en);
      chk("R11 wdt_lock", wdt_lock, m_lk);
      chk("R8 rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input bit cfg, input int a, input int sz, input logic [31:0] d);
    @(negedge clk);
    bus_cfg = cfg; bus_addr = AW'(a); bus_size = 2'(sz); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input bit cfg, input int a, input int sz);
    @(negedge clk);
    bus_cfg = cfg; bus_addr = AW'(a); bus_size = 2'(sz); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic unlock();
    wr(0, 12, 0, 32'h80);
    wr(0, 12, 0, 32'h86);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5ns * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 preload1", preload1, 'hFFFFF);
    chk("R1 preload2", preload2, 'hFFFFF);
    chk("R1 reboot_en", reboot_en, 1);
    chk("R1 fields", {fast_clk, irq_type, free_run, wdt_en, wdt_lock, kick, flag_clr}, 0);
    chk("R1 rdata", bus_rdata, 0);
    rst_n = 1'b1;
    armed_cmp = 1;

    // R2 / R4 byte handshake then word preload
    unlock();
    wr(0, 0, 2, 32'hABC1_2345);
    chk("R4 preload1 loaded", preload1, 'h12345);
    // R2 half then word handshake, preload2
    wr(0, 12, 1, 32'h0000_0080);
    wr(0, 12, 2, 32'h0000_0086);
    wr(0, 4, 2, 32'h0007_00A5);
    chk("R4 preload2 loaded", preload2, 'h700A5);
    // R2 other write while armed keeps it armed
    wr(0, 12, 0, 32'h80);
    wr(0, 8, 2, 32'h0);
    wr(0, 12, 0, 32'h86);
    wr(0, 0, 2, 32'h0000_0AAA);
    chk("R2 armed survives", preload1, 'h00AAA);

    // R3 0x86 without arming, and width-cut value 0x180 not a key
    wr(0, 12, 0, 32'h86);
    wr(0, 0, 2, 32'h11111);
    chk("R3 no open", preload1, 'h00AAA);
    wr(0, 12, 1, 32'h0180);
    wr(0, 12, 0, 32'h86);
    wr(0, 4, 2, 32'h22222);
    chk("R3 wide value not key", preload2, 'h700A5);

    // R5 kick
    unlock();
    wr(0, 12, 1, 32'h0100);
    chk("R5 kick high", kick, 1);
    chk("R5 no clr", flag_clr, 0);
    @(negedge clk);
    chk("R5 kick one cycle", kick, 0);
    // R6 clear via bit 9, bit 12, and both pulses
    unlock();
    wr(0, 12, 1, 32'h0200);
    chk("R6 clr bit9", flag_clr, 1);
    unlock();
    wr(0, 12, 1, 32'h1000);
    chk("R6 clr bit12", flag_clr, 1);
    unlock();
    wr(0, 12, 1, 32'h0300);
    chk("R6 both pulses", {kick, flag_clr}, 2'b11);

    // R7 spent by no-effect write, byte write, repeated 0x86, second service
    unlock();
    wr(0, 8, 2, 32'h0);
    wr(0, 0, 2, 32'h55555);
    chk("R7 spent by no-op", preload1, 'h00AAA);
    unlock();
    wr(0, 0, 0, 32'h33);
    wr(0, 0, 2, 32'h55555);
    chk("R7 spent by byte", preload1, 'h00AAA);
    unlock();
    wr(0, 12, 0, 32'h86);
    wr(0, 0, 2, 32'h55555);
    chk("R7 spent by 0x86", preload1, 'h00AAA);
    unlock();
    wr(0, 12, 1, 32'h0100);
    wr(0, 12, 1, 32'h0100);
    chk("R7 second kick dropped", kick, 0);

    // R8 reads
    prev_reboot = 1'b1;
    rd(0, 12, 1);
    chk("R8 flag set", bus_rdata, 'h1200);
    repeat (3) @(negedge clk);
    chk("R8 hold", bus_rdata, 'h1200);
    rd(0, 12, 0);
    chk("R8 byte read zero", bus_rdata, 0);
    rd(0, 12, 1);
    rd(0, 12, 2);
    chk("R8 word read zero", bus_rdata, 0);
    rd(0, 0, 2);
    chk("R8 preload read zero", bus_rdata, 0);
    prev_reboot = 1'b0;
    rd(0, 12, 1);
    chk("R8 flag clear", bus_rdata, 0);

    // R9 control register
    wr(1, 0, 1, 32'h0027);
    chk("R9 fields", {reboot_en, fast_clk, irq_type}, 4'b0111);
    rd(1, 0, 1);
    chk("R9 readback", bus_rdata, 'h27);
    wr(1, 0, 2, 32'h0);
    chk("R9 word ignored", {reboot_en, fast_clk, irq_type}, 4'b0111);
    rd(1, 0, 0);
    chk("R9 byte read zero", bus_rdata, 0);
    wr(1, 0, 1, 32'h0002);
    chk("R9 rewrite", {reboot_en, fast_clk, irq_type}, 4'b1010);

    // R12 config accesses leave the sequence alone
    wr(0, 12, 0, 32'h80);
    wr(1, 0, 1, 32'h0001);
    wr(0, 12, 0, 32'h86);
    wr(1, 0, 1, 32'h0000);
    wr(0, 0, 2, 32'h0BEEF);
    chk("R12 handshake intact", preload1, 'h0BEEF);

    // R10 lock register
    wr(1, 4, 0, 32'h06);
    chk("R10 fields", {free_run, wdt_en, wdt_lock}, 3'b110);
    rd(1, 4, 0);
    chk("R10 readback", bus_rdata, 6);
    wr(1, 4, 1, 32'h00);
    chk("R10 half ignored", {free_run, wdt_en, wdt_lock}, 3'b110);
    // R11 sticky lock
    wr(1, 4, 0, 32'h03);
    chk("R11 locked", {free_run, wdt_en, wdt_lock}, 3'b011);
    wr(1, 4, 0, 32'h04);
    chk("R11 write ignored", {free_run, wdt_en, wdt_lock}, 3'b011);
    rd(1, 4, 0);
    chk("R11 readback", bus_rdata, 3);

    // R1 second reset clears lock and preloads
    armed_cmp = 0;
    do_reset();
    @(negedge clk);
    chk("R1 lock cleared", {free_run, wdt_en, wdt_lock}, 0);
    chk("R1 preload1 again", preload1, 'hFFFFF);
    armed_cmp = 1;
    wr(1, 4, 0, 32'h02);
    chk("R11 writable after reset", wdt_en, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule